// File: doc/BRIEF.md
# Host-to-DSP memory window bridge

This block sits on the host side of a DSP and lets a 16-bit I/O bus reach the DSP's data store and instruction store indirectly. The host first loads a 32-bit window address through two 16-bit address ports. It then moves words through data ports. The address can step forward on its own after each access, so a block transfer needs only one address load.

Instruction-store words are 32 bits wide and pass through two 16-bit ports. The host touches the low half first and the high half second. Address bit 22 selects the instruction store. A separate port reads a data-store word and clears it, which suits mailbox-style consumption.

The block also holds the DSP-to-host interrupt pending bits and the enable that gates the host interrupt line. Both stores are modelled as small internal RAMs. The host side is a single-cycle port: read data is valid combinationally in the cycle of the strobe, and side effects take place at the following clock edge.

Top module: `dsp_window_bridge`

## Requirements
- R1: After reset the window address, the control bits, the low-half holding register, the pending bits, both stores and `host_irq` are all zero.
- R2: Port code 0 reads and writes address bits [15:0]; port code 1 reads and writes address bits [31:16].
- R3: While address bit 22 is 0, port code 2 reads or writes the data-store word at index address[DS_AW-1:0].
- R4: While address bit 22 is 1, the instruction-store entry at index address[IS_AW+1:2] is reached as follows. Port code 3 reads bits [15:0] of the entry, and a write to port code 3 loads a holding register. Port code 2 reads bits [31:16] of the entry. A write to port code 2 stores {write data, holding register} into the entry. While bit 22 is 0, port code 3 reads zero and ignores writes.
- R5: With control bit 0 set, every port-code-2 access adds 1 to the address for the data store and 4 for the instruction store, and every port-code-4 read adds 1. Port code 3 never moves the address. With control bit 0 clear, no access moves the address.
- R6: A read of port code 4 while bit 22 is 0 returns the addressed data-store word and writes zero into that word. While bit 22 is 1, it returns zero and changes nothing. Writes to port code 4 have no effect.
- R7: Port code 5 holds four control bits, with the upper twelve bits reading zero. Bit 0 enables memory auto-increment, bit 1 is the I/O auto-increment flag, bit 2 is the diagnostic flag and bit 3 is the host interrupt enable. Bits 1 and 2 are stored and read back only.
- R8: Port code 6 reads the pending bits. A write keeps each pending bit whose data bit is 1 and clears each bit whose data bit is 0, so writing the complement of a value just read clears exactly the bits that were set in it.
- R9: A bit of `dsp_raise` sets the matching pending bit at the next edge, even when a host write in the same cycle clears that bit.
- R10: `host_irq` is 1 exactly when control bit 3 is 1 and at least one pending bit is 1. Port code 7 reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_valid | input | 1 | Host access strobe, one access per cycle |
| io_write | input | 1 | 1 = write, 0 = read |
| io_port | input | 3 | Port code 0 to 7 |
| io_wdata | input | 16 | Host write data |
| io_rdata | output | 16 | Host read data, valid in the strobe cycle |
| dsp_raise | input | PEND_W | DSP interrupt requests, one per pending bit |
| host_irq | output | 1 | Gated interrupt to the host |

## Verification
Two functions can fall in the same cycle: the DSP raising a pending bit, and a host write to the pending port that clears the same bit. The bench provokes this by driving `dsp_raise` in the cycle of a clearing write, in directed cases and at random during the mixed phase. It then judges the result by reading the pending port back and by watching `host_irq`. A second overlap also comes up: an auto-increment stepping across bit 22 or wrapping the store index while a half-word is held. The bench's reference model checks this case on every read.

// File: rtl/dw_pkg.sv
package dw_pkg;
    localparam logic [2:0] PORT_ALO = 3'd0;
    localparam logic [2:0] PORT_AHI = 3'd1;
    localparam logic [2:0] PORT_DAT = 3'd2;
    localparam logic [2:0] PORT_ILO = 3'd3;
    localparam logic [2:0] PORT_RAC = 3'd4;
    localparam logic [2:0] PORT_CTL = 3'd5;
    localparam logic [2:0] PORT_PND = 3'd6;

    localparam int CTRL_W     = 4;
    localparam int C_MINC     = 0;
    localparam int C_IEN      = 3;
    localparam int IS_SEL_BIT = 22;

    typedef struct packed {
        logic [31:0]       addr;
        logic [CTRL_W-1:0] ctrl;
        logic [15:0]       lo_hold;
    } win_state_t;
endpackage

// File: rtl/dw_store.sv
module dw_store #(
    parameter int W     = 16,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] cell_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (!rst_n)
                cell_q[g] <= '0;
            else if (we && idx == AW'(g))
                cell_q[g] <= wdata;
        end
    end

    assign rdata = cell_q[idx];
endmodule

// File: rtl/dw_irq.sv
module dw_irq #(
    parameter int PEND_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PEND_W-1:0] raise,
    input  logic              keep_we,
    input  logic [PEND_W-1:0] keep_mask,
    input  logic              enable,
    output logic [PEND_W-1:0] pend,
    output logic              irq
);
    typedef struct packed {
        logic [PEND_W-1:0] pend;
    } irq_state_t;

    irq_state_t irq_d, irq_q;

    always_comb begin
        irq_d = irq_q;
        if (keep_we)
            irq_d.pend = irq_q.pend & keep_mask;
        irq_d.pend = irq_d.pend | raise;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= '0;
        else
            irq_q <= irq_d;
    end

    assign pend = irq_q.pend;
    assign irq  = enable & (|irq_q.pend);
endmodule

// File: rtl/dsp_window_bridge.sv
module dsp_window_bridge
    import dw_pkg::*;
#(
    parameter int DS_DEPTH = 16,
    parameter int IS_DEPTH = 16,
    parameter int PEND_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_valid,
    input  logic              io_write,
    input  logic [2:0]        io_port,
    input  logic [15:0]       io_wdata,
    output logic [15:0]       io_rdata,
    input  logic [PEND_W-1:0] dsp_raise,
    output logic              host_irq
);
    localparam int DS_AW = $clog2(DS_DEPTH);
    localparam int IS_AW = $clog2(IS_DEPTH);

    win_state_t state_d, state_q;

    logic              ds_we, is_we, pnd_we;
    logic [15:0]       ds_wd, ds_rd;
    logic [31:0]       is_wd, is_rd;
    logic [DS_AW-1:0]  ds_idx;
    logic [IS_AW-1:0]  is_idx;
    logic [PEND_W-1:0] pend_vec;
    logic              is_sel, minc;
    logic [31:0]       cur_addr;
    logic [CTRL_W-1:0] cur_ctrl;

    assign is_sel   = state_q.addr[IS_SEL_BIT];
    assign minc     = state_q.ctrl[C_MINC];
    assign ds_idx   = state_q.addr[DS_AW-1:0];
    assign is_idx   = state_q.addr[IS_AW+1:2];
    assign cur_addr = state_q.addr;
    assign cur_ctrl = state_q.ctrl;

    always_comb begin
        state_d  = state_q;
        ds_we    = 1'b0;
        ds_wd    = '0;
        is_we    = 1'b0;
        is_wd    = '0;
        pnd_we   = 1'b0;
        io_rdata = '0;
        if (io_valid) begin
            case (io_port)
                PORT_ALO: begin
                    io_rdata = state_q.addr[15:0];
                    if (io_write) state_d.addr[15:0] = io_wdata;
                end
                PORT_AHI: begin
                    io_rdata = state_q.addr[31:16];
                    if (io_write) state_d.addr[31:16] = io_wdata;
                end
                PORT_DAT: begin
                    if (is_sel) begin
                        io_rdata = is_rd[31:16];
                        if (io_write) begin
                            is_we = 1'b1;
                            is_wd = {io_wdata, state_q.lo_hold};
                        end
                        if (minc) state_d.addr = state_q.addr + 32'd4;
                    end else begin
                        io_rdata = ds_rd;
                        if (io_write) begin
                            ds_we = 1'b1;
                            ds_wd = io_wdata;
                        end
                        if (minc) state_d.addr = state_q.addr + 32'd1;
                    end
                end
                PORT_ILO: begin
                    if (is_sel) begin
                        io_rdata = is_rd[15:0];
                        if (io_write) state_d.lo_hold = io_wdata;
                    end
                end
                PORT_RAC: begin
                    if (!is_sel && !io_write) begin
                        io_rdata = ds_rd;
                        ds_we    = 1'b1;
                        ds_wd    = '0;
                        if (minc) state_d.addr = state_q.addr + 32'd1;
                    end
                end
                PORT_CTL: begin
                    io_rdata = 16'(state_q.ctrl);
                    if (io_write) state_d.ctrl = io_wdata[CTRL_W-1:0];
                end
                PORT_PND: begin
                    io_rdata = 16'(pend_vec);
                    pnd_we   = io_write;
                end
                default: io_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    dw_store #(.W(16), .DEPTH(DS_DEPTH)) u_ds (
        .clk(clk), .rst_n(rst_n), .we(ds_we), .idx(ds_idx),
        .wdata(ds_wd), .rdata(ds_rd)
    );

    dw_store #(.W(32), .DEPTH(IS_DEPTH)) u_is (
        .clk(clk), .rst_n(rst_n), .we(is_we), .idx(is_idx),
        .wdata(is_wd), .rdata(is_rd)
    );

    dw_irq #(.PEND_W(PEND_W)) u_irq (
        .clk(clk), .rst_n(rst_n), .raise(dsp_raise),
        .keep_we(pnd_we), .keep_mask(io_wdata[PEND_W-1:0]),
        .enable(state_q.ctrl[C_IEN]), .pend(pend_vec), .irq(host_irq)
    );
endmodule

// File: rtl/dw_bridge_chk.sv
module dw_bridge_chk
    import dw_pkg::*;
#(
    parameter int PEND_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_valid,
    input logic              io_write,
    input logic [2:0]        io_port,
    input logic [15:0]       io_wdata,
    input logic [31:0]       addr,
    input logic [CTRL_W-1:0] ctrl,
    input logic [PEND_W-1:0] pend,
    input logic [PEND_W-1:0] raise
);
    // R2
    alo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_write && io_port == PORT_ALO) |=> (addr[15:0] == $past(io_wdata)));

    // R5
    ilo_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_port == PORT_ILO) |=> (addr == $past(addr)));

    // R5
    ds_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_port == PORT_DAT && !addr[IS_SEL_BIT] && ctrl[C_MINC])
        |=> (addr == $past(addr) + 32'd1));

    // R5
    is_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_port == PORT_DAT && addr[IS_SEL_BIT] && ctrl[C_MINC])
        |=> (addr == $past(addr) + 32'd4));

    // R5
    no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_port == PORT_DAT && !ctrl[C_MINC]) |=> (addr == $past(addr)));

    // R8
    pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (io_valid && io_write && io_port == PORT_PND && raise == '0)
        |=> (pend == ($past(pend) & $past(io_wdata[PEND_W-1:0]))));

    // R9
    raise_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raise != '0) |=> ((pend & $past(raise)) == $past(raise)));
endmodule

bind dsp_window_bridge dw_bridge_chk #(.PEND_W(PEND_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
    .io_port(io_port), .io_wdata(io_wdata), .addr(cur_addr), .ctrl(cur_ctrl),
    .pend(pend_vec), .raise(dsp_raise)
);

// File: tb/tb_dsp_window_bridge.sv
module tb_dsp_window_bridge;
    localparam int PEND_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              io_valid = 1'b0, io_write = 1'b0;
    logic [2:0]        io_port = '0;
    logic [15:0]       io_wdata = '0;
    logic [15:0]       io_rdata;
    logic [PEND_W-1:0] dsp_raise = '0;
    logic              host_irq;

    always #4 clk = ~clk;

    dsp_window_bridge #(.DS_DEPTH(16), .IS_DEPTH(16), .PEND_W(PEND_W)) dut (
        .clk(clk), .rst_n(rst_n), .io_valid(io_valid), .io_write(io_write),
        .io_port(io_port), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .dsp_raise(dsp_raise), .host_irq(host_irq)
    );

    int n_chk = 0, n_bad = 0;
    logic [31:0]       m_addr;
    logic [3:0]        m_ctrl;
    logic [15:0]       m_lo;
    logic [PEND_W-1:0] m_pend;
    logic [15:0]       m_ds [16];
    logic [31:0]       m_is [16];

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] p);
        case (p)
            3'd0, 3'd1: return "R2";
            3'd2:       return "R3/R4 data port";
            3'd3:       return "R4";
            3'd4:       return "R6";
            3'd5:       return "R7";
            3'd6:       return "R8";
            default:    return "R10 unused port";
        endcase
    endfunction

    // Reference model: returns the expected read value, then updates state.
    task automatic model(input logic [2:0] p, input bit wr, input logic [15:0] wd,
                         input logic [PEND_W-1:0] rz, output logic [15:0] exp);
        bit sel = m_addr[22];
        int di  = int'(m_addr[3:0]);
        int ii  = int'(m_addr[5:2]);
        exp = '0;
        case (p)
            3'd0: begin exp = m_addr[15:0];  if (wr) m_addr[15:0]  = wd; end
            3'd1: begin exp = m_addr[31:16]; if (wr) m_addr[31:16] = wd; end
            3'd2: begin
                if (sel) begin
                    exp = m_is[ii][31:16];
                    if (wr) m_is[ii] = {wd, m_lo};
                    if (m_ctrl[0]) m_addr = m_addr + 32'd4;
                end else begin
                    exp = m_ds[di];
                    if (wr) m_ds[di] = wd;
                    if (m_ctrl[0]) m_addr = m_addr + 32'd1;
                end
            end
            3'd3: if (sel) begin exp = m_is[ii][15:0]; if (wr) m_lo = wd; end
            3'd4: if (sel == 1'b0 && !wr) begin
                exp = m_ds[di];
                m_ds[di] = '0;
                if (m_ctrl[0]) m_addr = m_addr + 32'd1;
            end
            3'd5: begin exp = {12'h000, m_ctrl}; if (wr) m_ctrl = wd[3:0]; end
            3'd6: begin exp = 16'(m_pend); if (wr) m_pend = m_pend & wd[PEND_W-1:0]; end
            default: exp = '0;
        endcase
        m_pend = m_pend | rz;
    endtask

    // One bus cycle; read data sampled 1 ns after the driving edge.
    task automatic op(input logic [2:0] p, input bit wr, input logic [15:0] wd,
                      input logic [PEND_W-1:0] rz, input string tag);
        logic [15:0] got, exp;
        @(negedge clk);
        io_valid = 1'b1; io_write = wr; io_port = p; io_wdata = wd; dsp_raise = rz;
        #1 got = io_rdata;
        model(p, wr, wd, rz, exp);
        if (!wr) check(tag, 32'(got), 32'(exp));
        @(posedge clk);
        #1 io_valid = 1'b0; dsp_raise = '0;
        check("R10 host_irq", 32'(host_irq), 32'(m_ctrl[3] && (m_pend != '0)));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired, got running expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        m_addr = '0; m_ctrl = '0; m_lo = '0; m_pend = '0;
        for (int i = 0; i < 16; i++) begin m_ds[i] = '0; m_is[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state via every read port
        check("R1 host_irq", 32'(host_irq), 32'd0);
        for (int p = 0; p < 8; p++) op(3'(p), 1'b0, 16'h0, '0, "R1 reset read");

        // R2 address halves
        op(3'd0, 1'b1, 16'h1234, '0, "R2");
        op(3'd1, 1'b1, 16'h0000, '0, "R2");
        op(3'd0, 1'b0, 16'h0, '0, "R2 low half");
        op(3'd1, 1'b0, 16'h0, '0, "R2 high half");

        // R3 + R5 data store block with auto-increment
        op(3'd5, 1'b1, 16'h0001, '0, "R7");
        op(3'd0, 1'b1, 16'h000E, '0, "R2");
        for (int k = 0; k < 4; k++) op(3'd2, 1'b1, 16'hA000 + 16'(k), '0, "R3");
        op(3'd0, 1'b1, 16'h000E, '0, "R2");
        for (int k = 0; k < 4; k++) op(3'd2, 1'b0, 16'h0, '0, "R3 wrap read");
        op(3'd0, 1'b0, 16'h0, '0, "R5 address after 4 steps");

        // R6 read-and-clear then re-read
        op(3'd0, 1'b1, 16'h000F, '0, "R2");
        op(3'd4, 1'b0, 16'h0, '0, "R6 first read");
        op(3'd0, 1'b1, 16'h000F, '0, "R2");
        op(3'd2, 1'b0, 16'h0, '0, "R6 cleared word");

        // R4 instruction store, entry 5, low then high
        op(3'd1, 1'b1, 16'h0040, '0, "R2");
        op(3'd0, 1'b1, 16'h0014, '0, "R2");
        op(3'd3, 1'b1, 16'hBEEF, '0, "R4");
        op(3'd0, 1'b0, 16'h0, '0, "R5 no step on low half");
        op(3'd2, 1'b1, 16'hDEAD, '0, "R4");
        op(3'd0, 1'b0, 16'h0, '0, "R5 step by 4");
        op(3'd0, 1'b1, 16'h0014, '0, "R2");
        op(3'd3, 1'b0, 16'h0, '0, "R4 low half");
        op(3'd2, 1'b0, 16'h0, '0, "R4 high half");
        op(3'd4, 1'b0, 16'h0, '0, "R6 ignored in instruction store");

        // R8/R9/R10 pending and gating
        op(3'd5, 1'b1, 16'h0008, '0, "R7");
        op(3'd6, 1'b0, 16'h0, 8'h5A, "R8");
        op(3'd6, 1'b0, 16'h0, '0, "R8 after raise");
        op(3'd6, 1'b1, 16'hFFA5, 8'h02, "R9 clear with same-cycle raise");
        op(3'd6, 1'b0, 16'h0, '0, "R9 raised bit survives");
        op(3'd5, 1'b1, 16'h0000, '0, "R10 gate off");
        op(3'd6, 1'b1, 16'h0000, '0, "R8 clear all");
        op(3'd5, 1'b1, 16'h0006, '0, "R7");
        op(3'd5, 1'b0, 16'h0, '0, "R7 readback");
        op(3'd7, 1'b1, 16'hFFFF, '0, "R10 unused port");

        // Mixed random phase
        void'($urandom(32'd2024));
        for (int n = 0; n < 3000; n++) begin
            logic [2:0]        p  = 3'($urandom % 8);
            bit                wr = 1'($urandom);
            logic [15:0]       wd = 16'($urandom);
            logic [PEND_W-1:0] rz = ($urandom % 5 == 0) ? PEND_W'($urandom) : '0;
            if (p == 3'd1) wd = ($urandom % 2 == 0) ? 16'h0040 : 16'h0000;
            op(p, wr, wd, rz, tag_of(p));
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule